// File: doc/BRIEF.md
# Cascadable Six-Bit Up/Down Counter with Registered Carries

This block is a synchronous counter, six bits wide by default, that can load a preset value, count up, count down or hold. A two-bit mode input selects the operation. Counting takes place only while two active-low enables, a carry-in and a look-ahead carry-in, are both low. This lets several stages be chained into one wider counter. An asynchronous, active-high reset clears the count.

Each stage drives two active-low carry flags. The carry-out marks the cycle in which the stage sits at its terminal count. The look-ahead carry-out marks the cycle one count earlier. Both flags are flip-flop outputs. They are computed from the next-state value at the same edge that updates the count, so each flag is valid in the same cycle as the count it marks and never glitches.

To build a wider counter, the carry-out of the lower stage is wired to the carry-in of the next stage. All stages share the same mode and each receives its slice of the preset.

Top module: `updn_ctr6`

## Requirements
- R1: While rst is high, count is 0 and both co_n and lco_n are 1. This takes effect without a clock edge and overrides every other input.
- R2: With mode_sel = 2'b00, count takes preset at the next rising edge whatever the values of cin_n and lcin_n.
- R3: With mode_sel = 2'b01 and both cin_n and lcin_n low, count increases by one at each edge, and the maximum value wraps to 0.
- R4: With mode_sel = 2'b10 and both cin_n and lcin_n low, count decreases by one at each edge, and 0 wraps to the maximum value.
- R5: With mode_sel = 2'b11, count keeps its value whatever the values of cin_n and lcin_n.
- R6: In modes 2'b01 and 2'b10, count keeps its value during any cycle in which cin_n or lcin_n is high.
- R7: co_n is 0 for exactly the one cycle after an edge at which the counter stepped into its terminal value (the all-ones value when counting up, 0 when counting down). Otherwise it is 1.
- R8: lco_n is 0 for exactly the one cycle after an edge at which the counter stepped into the value one count before terminal (all-ones minus one when counting up, 1 when counting down). Otherwise it is 1.
- R9: A count reached by a load, or kept by hold or by a high enable, raises no flag. co_n and lco_n are 1 after such an edge, even when the count is a terminal value.
- R10: When two stages share mode_sel, the lower stage has its enables low, and the lower co_n drives the upper cin_n, the pair {upper count, lower count} loads, counts up and counts down as one 12-bit counter, including wrap-around in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| mode_sel | input | 2 | 00 load, 01 up, 10 down, 11 hold |
| preset | input | WIDTH | Value taken in load mode |
| cin_n | input | 1 | Carry-in enable, active low |
| lcin_n | input | 1 | Look-ahead carry-in enable, active low |
| count | output | WIDTH | Current count |
| co_n | output | 1 | Registered carry-out, active low |
| lco_n | output | 1 | Registered look-ahead carry-out, active low |

## Verification
The hardest case to reach is the upper stage of a chain stepping at the exact edge where the lower stage wraps. That edge depends on a flag registered one cycle earlier, and it only occurs after long runs of counting. The stimulus reaches it by loading a 12-bit value a few counts short of a lower-stage wrap in each direction, then running long sequences that cross many wraps, including a wrap of the full 12 bits. Separate runs load a terminal value directly and stall the lower stage at its terminal value, to show that neither case raises a flag.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_HOLD = 2'b11
  } ctr_mode_e;

  // mask of the low w bits
  function automatic logic [31:0] ctr_mask(input int unsigned w);
    logic [31:0] m;
    if (w >= 32) m = '1;
    else         m = (32'd1 << w) - 32'd1;
    return m;
  endfunction

  // one step in the chosen direction, wrapping inside w bits
  function automatic logic [31:0] ctr_step(input logic [31:0] v, input logic up,
                                           input int unsigned w);
    logic [31:0] r;
    if (up) r = v + 32'd1;
    else    r = v - 32'd1;
    return r & ctr_mask(w);
  endfunction

  // value at which the carry-out fires
  function automatic logic [31:0] ctr_end_value(input logic up, input int unsigned w);
    return up ? ctr_mask(w) : 32'd0;
  endfunction

  // value one count before the end value
  function automatic logic [31:0] ctr_pre_value(input logic up, input int unsigned w);
    return up ? (ctr_mask(w) - 32'd1) : 32'd1;
  endfunction

endpackage

// File: rtl/updn_mode_dec.sv
module updn_mode_dec
  import updn_ctr_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       cin_n,
  input  logic       lcin_n,
  output logic       load_en,
  output logic       step_en,
  output logic       dir_up
);
  ctr_mode_e mode;
  logic      count_mode;

  always_comb begin
    mode       = ctr_mode_e'(mode_sel);
    load_en    = (mode == MODE_LOAD);
    count_mode = (mode == MODE_UP) || (mode == MODE_DOWN);
    step_en    = count_mode && !cin_n && !lcin_n;
    dir_up     = (mode == MODE_UP);
  end
endmodule

// File: rtl/updn_next_state.sv
module updn_next_state
  import updn_ctr_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  input  logic             load_en,
  input  logic             step_en,
  input  logic             dir_up,
  output logic [WIDTH-1:0] nxt,
  output logic             hit_end,
  output logic             hit_pre
);
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] end_val;
  logic [WIDTH-1:0] pre_val;

  always_comb begin
    stepped = WIDTH'(ctr_step(32'(cur), dir_up, WIDTH));
    end_val = WIDTH'(ctr_end_value(dir_up, WIDTH));
    pre_val = WIDTH'(ctr_pre_value(dir_up, WIDTH));
    if (load_en)      nxt = preset;
    else if (step_en) nxt = stepped;
    else              nxt = cur;
    // flags only when the stage actually steps into the value
    hit_end = step_en && (stepped == end_val);
    hit_pre = step_en && (stepped == pre_val);
  end
endmodule

// File: rtl/updn_flag_reg.sv
module updn_flag_reg #(
  parameter int NUM_FLAGS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] fire,
  output logic [NUM_FLAGS-1:0] flag_n
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or posedge rst) begin
      if (rst) flag_n[g] <= 1'b1;
      else     flag_n[g] <= !fire[g];
    end
  end
endmodule

// File: rtl/updn_ctr6.sv
module updn_ctr6 #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic [WIDTH-1:0] preset,
  input  logic             cin_n,
  input  logic             lcin_n,
  output logic [WIDTH-1:0] count,
  output logic             co_n,
  output logic             lco_n
);
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_END  = 0;
  localparam int FLAG_PRE  = 1;

  logic                 load_en;
  logic                 step_en;
  logic                 dir_up;
  logic [WIDTH-1:0]     nxt_count;
  logic                 hit_end;
  logic                 hit_pre;
  logic [NUM_FLAGS-1:0] fire;
  logic [NUM_FLAGS-1:0] flag_n;

  updn_mode_dec dec_i (
    .mode_sel (mode_sel),
    .cin_n    (cin_n),
    .lcin_n   (lcin_n),
    .load_en  (load_en),
    .step_en  (step_en),
    .dir_up   (dir_up)
  );

  updn_next_state #(.WIDTH(WIDTH)) nxt_i (
    .cur      (count),
    .preset   (preset),
    .load_en  (load_en),
    .step_en  (step_en),
    .dir_up   (dir_up),
    .nxt      (nxt_count),
    .hit_end  (hit_end),
    .hit_pre  (hit_pre)
  );

  always_comb begin
    fire           = '0;
    fire[FLAG_END] = hit_end;
    fire[FLAG_PRE] = hit_pre;
  end

  updn_flag_reg #(.NUM_FLAGS(NUM_FLAGS)) flag_i (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .flag_n (flag_n)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) count <= '0;
    else     count <= nxt_count;
  end

  assign co_n  = flag_n[FLAG_END];
  assign lco_n = flag_n[FLAG_PRE];
endmodule

// File: rtl/updn_ctr6_chk.sv
module updn_ctr6_chk #(
  parameter int WIDTH = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic [WIDTH-1:0] preset,
  input logic             cin_n,
  input logic             lcin_n,
  input logic [WIDTH-1:0] count,
  input logic             co_n,
  input logic             lco_n
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always @(negedge clk) begin
    if (rst) AST_RESET_STATE: assert (count == '0 && co_n && lco_n); // R1
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00) |=> (count == $past(preset))); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && !cin_n && !lcin_n) |=> (count == WIDTH'($past(count) + ONE))); // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10 && !cin_n && !lcin_n) |=> (count == WIDTH'($past(count) - ONE))); // R4
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |=> $stable(count)); // R5
  AST_GATE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 2'b01 || mode_sel == 2'b10) && (cin_n || lcin_n)) |=> $stable(count)); // R6
  AST_CO_AT_END: assert property (@(posedge clk) disable iff (rst)
    !co_n |-> (count == TOP || count == '0)); // R7
  AST_CO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !co_n |=> co_n); // R7
  AST_LCO_AT_PRE: assert property (@(posedge clk) disable iff (rst)
    !lco_n |-> (count == TOP - ONE || count == ONE)); // R8
  AST_LCO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !lco_n |=> lco_n); // R8
  AST_NO_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00 || mode_sel == 2'b11) |=> (co_n && lco_n)); // R9
endmodule

bind updn_ctr6 updn_ctr6_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .preset(preset), .cin_n(cin_n),
  .lcin_n(lcin_n), .count(count), .co_n(co_n), .lco_n(lco_n)
);

// File: tb/updn_ctr6_tb_top.sv
module updn_ctr6_tb_top;
  localparam int W    = 6;
  localparam int MAXV = (1 << W) - 1;
  localparam int M12  = (1 << (2 * W)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]   mode = 2'b11;
  logic [W-1:0] pre_lo = '0, pre_hi = '0;
  logic lo_cin_n = 1'b0, lo_lcin_n = 1'b0, hi_lcin_n = 1'b0;
  logic [W-1:0] q_lo, q_hi;
  logic co_lo, lco_lo, co_hi, lco_hi;

  int errors = 0;
  int checks = 0;

  updn_ctr6 #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode), .preset(pre_lo), .cin_n(lo_cin_n),
    .lcin_n(lo_lcin_n), .count(q_lo), .co_n(co_lo), .lco_n(lco_lo)
  );
  updn_ctr6 #(.WIDTH(W)) dut_hi_i (
    .clk(clk), .rst(rst), .mode_sel(mode), .preset(pre_hi), .cin_n(co_lo),
    .lcin_n(hi_lcin_n), .count(q_hi), .co_n(co_hi), .lco_n(lco_hi)
  );

  // behavioural model state
  int m_lo = 0, m_hi = 0, ref12 = 0;
  bit mco_lo = 1, mlco_lo = 1, mco_hi = 1, mlco_hi = 1;
  bit chk12 = 0;
  string tq_lo = "R1", tq_hi = "R1", tc_lo = "R1", tc_hi = "R1", tl_lo = "R1", tl_hi = "R1";

  task automatic model_stage(input int q, input int pv, input bit en_a, input bit en_b,
                             output int nq, output bit nco, output bit nlco,
                             output string tq, output string tc, output string tl);
    bit up, cnt, adv;
    int term, pre;
    up   = (mode == 2'b01);
    cnt  = (mode == 2'b01) || (mode == 2'b10);
    adv  = cnt && !en_a && !en_b;
    term = up ? MAXV : 0;
    pre  = up ? MAXV - 1 : 1;
    if (mode == 2'b00) begin nq = pv; tq = "R2"; end
    else if (adv) begin
      nq = up ? ((q + 1) % (MAXV + 1)) : ((q + MAXV) % (MAXV + 1));
      tq = up ? "R3" : "R4";
    end
    else begin nq = q; tq = cnt ? "R6" : "R5"; end
    nco  = !(adv && nq == term);
    nlco = !(adv && nq == pre);
    tc   = adv ? "R7" : "R9";
    tl   = adv ? "R8" : "R9";
  endtask

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_lo = 0; m_hi = 0; mco_lo = 1; mlco_lo = 1; mco_hi = 1; mlco_hi = 1;
      tq_lo = "R1"; tq_hi = "R1"; tc_lo = "R1"; tc_hi = "R1"; tl_lo = "R1"; tl_hi = "R1";
    end else begin
      int nl, nh; bit cl, ll, ch, lh;
      model_stage(m_lo, int'(pre_lo), lo_cin_n, lo_lcin_n, nl, cl, ll, tq_lo, tc_lo, tl_lo);
      model_stage(m_hi, int'(pre_hi), mco_lo, hi_lcin_n, nh, ch, lh, tq_hi, tc_hi, tl_hi);
      if (mode == 2'b00) ref12 = {pre_hi, pre_lo};
      else if (!lo_cin_n && !lo_lcin_n && mode == 2'b01) ref12 = (ref12 + 1) & M12;
      else if (!lo_cin_n && !lo_lcin_n && mode == 2'b10) ref12 = (ref12 + M12) & M12;
      m_lo = nl; m_hi = nh; mco_lo = cl; mlco_lo = ll; mco_hi = ch; mlco_hi = lh;
    end
  end

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check_eq(tq_lo, "lower count", int'(q_lo), m_lo);
    check_eq(tq_hi, "upper count", int'(q_hi), m_hi);
    check_eq(tc_lo, "lower co_n", int'(co_lo), int'(mco_lo));
    check_eq(tl_lo, "lower lco_n", int'(lco_lo), int'(mlco_lo));
    check_eq(tc_hi, "upper co_n", int'(co_hi), int'(mco_hi));
    check_eq(tl_hi, "upper lco_n", int'(lco_hi), int'(mlco_hi));
    if (chk12) check_eq("R10", "cascade value", int'({q_hi, q_lo}), ref12);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic load12(input int v, input logic [1:0] next_mode);
    mode = 2'b00; pre_lo = v[W-1:0]; pre_hi = v[2*W-1:W];
    run(1);
    mode = next_mode;
    chk12 = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check_eq("R1", "reset count", int'(q_lo), 0);
    check_eq("R1", "reset co_n", int'(co_lo), 1);
    check_eq("R1", "reset lco_n", int'(lco_lo), 1);
    rst = 1'b0;
    run(2);

    // R3 R10: long up run crossing many lower wraps
    load12(12'h005, 2'b01);
    run(140);
    // R10: full 12-bit wrap going up
    load12(12'hFFC, 2'b01);
    run(10);
    // R4 R10: down across 0, and a 12-bit wrap downward
    load12(12'h005, 2'b10);
    run(12);
    load12(12'h7A3, 2'b10);
    run(150);
    // mid-count load, then continue upward
    mode = 2'b01; load12(12'h33E, 2'b01);
    run(6);

    // R5: hold with enables toggled
    chk12 = 0;
    mode = 2'b11; lo_cin_n = 1'b1; run(2); lo_cin_n = 1'b0; run(2);
    // R6: look-ahead enable high stalls counting
    mode = 2'b01; lo_lcin_n = 1'b1; run(3); lo_lcin_n = 1'b0; run(2);
    // R2: load while the carry-in is high
    lo_cin_n = 1'b1; mode = 2'b00; pre_lo = 6'd17; pre_hi = 6'd40; run(1);
    check_eq("R2", "load with cin_n high", int'(q_lo), 17);
    lo_cin_n = 1'b0;
    // R9: load straight into terminal raises no flag
    pre_lo = 6'd63; run(1);
    check_eq("R9", "co_n after load of 63", int'(co_lo), 1);
    mode = 2'b01; run(2);
    // R9: stall at terminal clears the flag
    mode = 2'b00; pre_lo = 6'd61; run(1);
    mode = 2'b01; run(2);
    check_eq("R7", "co_n at 63 reached by step", int'(co_lo), 0);
    lo_cin_n = 1'b1; run(1);
    check_eq("R9", "co_n while stalled at 63", int'(co_lo), 1);
    lo_cin_n = 1'b0;
    // R8: look-ahead going down
    mode = 2'b00; pre_lo = 6'd3; run(1);
    mode = 2'b10; run(2);
    check_eq("R8", "lco_n at 1 going down", int'(lco_lo), 0);
    run(1);
    check_eq("R7", "co_n at 0 going down", int'(co_lo), 0);

    // R1: asynchronous reset in mid-count
    mode = 2'b01; run(3);
    #2 rst = 1'b1;
    #1 check_eq("R1", "async reset count", int'(q_lo), 0);
    check_eq("R1", "async reset co_n", int'(co_lo), 1);
    @(negedge clk); compare_all();
    rst = 1'b0;
    load12(12'hABC, 2'b10);
    run(20);
    finish_run();
  end
endmodule